// File: doc/BRIEF.md
# Receive/Transmit FIFO Pair with Ready Request Signalling

This block holds the host-side byte storage of a serial port: one queue toward the transmitter and one from the receiver, each 16 bytes deep when queueing is on and a single holding byte when it is off. The host writes transmit bytes and reads received bytes through strobes. The serial engine takes transmit bytes and delivers received bytes through push and pop strobes. A control byte written by the host turns queueing on or off, picks between two request styles, chooses a receive threshold and issues flush commands.

Two active-low request pins tell a DMA controller or host when to move data. Each pin follows one of three rule sets, picked by the control byte: queueing off, queueing on in request style 0, or queueing on in request style 1. In style 1 the receive request waits for the programmed threshold. A data-ready status bit reports whether any received byte is waiting, whatever the threshold.

Top module: `fifo_ready_ctrl`

## Requirements
- R1: After reset both queues are empty and the control byte is zero. At that point rxrdy_no=1, txrdy_no=0, data_ready_o=0 and tx_avail_o=0.
- R2: When control bit 0 is 0, each direction holds one byte. A host write while the transmit byte is held is ignored. A receive push while the receive byte is held is ignored, and the first byte is kept.
- R3: When control bit 0 is 0, txrdy_no goes high on the cycle after a host write. It returns low on the cycle after tx_pop_i, which marks the start of transmission.
- R4: When control bit 0 is 0, rxrdy_no goes low on the cycle after a receive push. It returns high on the cycle after the host read that empties the holding byte.
- R5: When control bit 0 is 1, each queue holds 16 bytes in first-in first-out order. A push into a full queue is ignored.
- R6: In style 0 (bit 0=1, bit 3=0), rxrdy_no is low while the receive queue holds at least one byte. txrdy_no is low only while the transmit queue is completely empty.
- R7: In style 1 (bit 0=1, bit 3=1), txrdy_no is high only while the transmit queue is completely full.
- R8: In style 1, rxrdy_no goes low once the receive count reaches the threshold and stays low until the queue becomes empty. Control bits 7:6 select the threshold: 00=1, 01=4, 10=8, 11=14.
- R9: data_ready_o is 1 while at least one received byte is waiting, independent of the threshold.
- R10: Writing the control byte with bit 1 set empties the receive queue; writing it with bit 2 set empties the transmit queue. Neither bit is stored, so a later write without them keeps the contents. A flush overrides a push or pop in the same cycle.
- R11: A control write that changes bit 0 empties both queues. A control write that keeps bit 0 leaves both queues intact.
- R12: When bit 0 is 0, bit 3 and bits 7:6 have no effect on the request pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fcr_we_i | input | 1 | Control byte write strobe |
| fcr_wdata_i | input | 8 | Control byte: bit0 queue enable, bit1 receive flush, bit2 transmit flush, bit3 style 1, bits7:6 threshold |
| thr_we_i | input | 1 | Host transmit byte write strobe |
| thr_wdata_i | input | 8 | Host transmit byte |
| rhr_re_i | input | 1 | Host receive byte read strobe (pops the head) |
| rhr_rdata_o | output | 8 | Head of receive queue |
| rx_push_i | input | 1 | Serial engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| tx_pop_i | input | 1 | Serial engine starts sending the head byte |
| tx_data_o | output | 8 | Head of transmit queue |
| tx_avail_o | output | 1 | Transmit queue not empty |
| data_ready_o | output | 1 | Receive queue not empty |
| rxrdy_no | output | 1 | Receive request, active low |
| txrdy_no | output | 1 | Transmit request, active low |

## Verification
Directed sequences first use the single-byte mode. They write a second byte into an occupied holding register, which separates the real one-byte limit from a hidden deep queue. Style 0 and style 1 are then driven with the same fill and drain patterns, and the pins must differ between them: the transmit request changes at empty in one style and at full in the other, and the receive request changes at one byte in one style and at the threshold in the other. Seeded random traffic mixes pushes, pops, reads, writes and occasional control writes. This catches hysteresis and flush interactions that the directed cases do not reach.

// File: rtl/fifo_ready_pkg.sv
package fifo_ready_pkg;
  typedef enum logic [1:0] {MODE_OFF, MODE_0, MODE_1} rdy_mode_e;

  // threshold select -> byte count, scaled to depth (16: 1,4,8,14)
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/fcr_reg.sv
module fcr_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic       fifo_en_o,
  output logic       dma_o,
  output logic [1:0] trig_sel_o,
  output logic       rx_flush_o,
  output logic       tx_flush_o
);
  logic       en_q, dma_q;
  logic [1:0] trig_q;
  logic       en_change;
  logic [1:0] unused_bits;

  assign unused_bits = wdata_i[5:4];
  assign en_change   = we_i && (wdata_i[0] != en_q);
  assign rx_flush_o  = (we_i && wdata_i[1]) || en_change;
  assign tx_flush_o  = (we_i && wdata_i[2]) || en_change;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= 2'd0;
    end else if (we_i) begin
      en_q   <= wdata_i[0];
      dma_q  <= wdata_i[3];
      trig_q <= wdata_i[7:6];
    end
  end

  assign fifo_en_o  = en_q;
  assign dma_o      = dma_q;
  assign trig_sel_o = trig_q;

  // R11: enable toggle flushes both directions
  p_toggle_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[0] != en_q) |-> (rx_flush_o && tx_flush_o));
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          single_i,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] cnt_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, cap;
  logic          do_push, do_pop;

  assign cap     = single_i ? CW'(1) : CW'(DEPTH);
  assign do_push = push_i && (cnt_q < cap) && !flush_i;
  assign do_pop  = pop_i && (cnt_q != '0) && !flush_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  assign dout_o = mem_q[rd_q];
  assign cnt_o  = cnt_q;

  // R5: push into a full queue leaves the count untouched
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == cap && push_i && !pop_i && !flush_i) |=> $stable(cnt_q));
  // R10: flush empties on the next cycle
  p_flush_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
  // R2: single-byte mode never holds more than one byte
  p_single_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_i |-> (cnt_q <= CW'(1)));
endmodule

// File: rtl/ready_gen.sv
module ready_gen
  import fifo_ready_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          dma_i,
  input  logic [1:0]    trig_sel_i,
  input  logic [CW-1:0] rx_cnt_i,
  input  logic [CW-1:0] tx_cnt_i,
  output logic          rxrdy_no,
  output logic          txrdy_no
);
  rdy_mode_e     mode;
  logic [CW-1:0] trig;
  logic          hold_q, m1_rx_act, rx_act, tx_act;

  assign mode = !fifo_en_i ? MODE_OFF : (dma_i ? MODE_1 : MODE_0);
  assign trig = CW'(trig_level(trig_sel_i, DEPTH));

  // style 1 receive request: set at threshold, held until empty
  assign m1_rx_act = (rx_cnt_i >= trig) || (hold_q && rx_cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= m1_rx_act;
  end

  always_comb begin
    case (mode)
      MODE_1: begin
        rx_act = m1_rx_act;
        tx_act = (tx_cnt_i != CW'(DEPTH));
      end
      default: begin
        rx_act = (rx_cnt_i != '0);
        tx_act = (tx_cnt_i == '0);
      end
    endcase
  end

  assign rxrdy_no = !rx_act;
  assign txrdy_no = !tx_act;

  // R8: request only rises at or above threshold in style 1
  p_rx_rise_trig_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rxrdy_no) && mode == MODE_1) |-> (rx_cnt_i >= trig));
  // R8: once raised, held while bytes remain
  p_rx_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_1 && $past(mode == MODE_1) && $past(!rxrdy_no) && rx_cnt_i != '0) |-> !rxrdy_no);
  // R6: style 0 transmit request never active with bytes queued
  p_tx_m0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode != MODE_1 && tx_cnt_i != '0) |-> txrdy_no);
endmodule

// File: rtl/fifo_ready_ctrl.sv
module fifo_ready_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fcr_we_i,
  input  logic [7:0]    fcr_wdata_i,
  input  logic          thr_we_i,
  input  logic [DW-1:0] thr_wdata_i,
  input  logic          rhr_re_i,
  output logic [DW-1:0] rhr_rdata_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_avail_o,
  output logic          data_ready_o,
  output logic          rxrdy_no,
  output logic          txrdy_no
);
  logic          fifo_en, dma, rx_flush, tx_flush;
  logic [1:0]    trig_sel;
  logic [CW-1:0] rx_cnt, tx_cnt;

  fcr_reg u_fcr (
    .clk_i, .rst_ni,
    .we_i(fcr_we_i), .wdata_i(fcr_wdata_i),
    .fifo_en_o(fifo_en), .dma_o(dma), .trig_sel_o(trig_sel),
    .rx_flush_o(rx_flush), .tx_flush_o(tx_flush)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i(rx_flush), .single_i(!fifo_en),
    .push_i(rx_push_i), .din_i(rx_data_i),
    .pop_i(rhr_re_i), .dout_o(rhr_rdata_o), .cnt_o(rx_cnt)
  );

  byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i(tx_flush), .single_i(!fifo_en),
    .push_i(thr_we_i), .din_i(thr_wdata_i),
    .pop_i(tx_pop_i), .dout_o(tx_data_o), .cnt_o(tx_cnt)
  );

  ready_gen #(.DEPTH(DEPTH)) u_ready (
    .clk_i, .rst_ni,
    .fifo_en_i(fifo_en), .dma_i(dma), .trig_sel_i(trig_sel),
    .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
    .rxrdy_no, .txrdy_no
  );

  assign data_ready_o = (rx_cnt != '0);
  assign tx_avail_o   = (tx_cnt != '0);

  // R7: full transmit queue in style 1 stays not-ready without a pop or control write
  p_tx_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en && dma && txrdy_no && !tx_pop_i && !fcr_we_i) |=> txrdy_no);
  // R9: status follows the receive push/read traffic
  p_dr_push_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rhr_re_i && !fcr_we_i) |=> data_ready_o);
endmodule

// File: tb/fifo_ready_ctrl_tb.sv
module fifo_ready_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fcr_we = 0, thr_we = 0, rhr_re = 0, rx_push = 0, tx_pop = 0;
  logic [7:0] fcr_d = 0, thr_d = 0, rx_d = 0;
  logic [7:0] rhr_q, tx_q;
  logic       tx_avail, dr, rxrdy_n, txrdy_n;

  int n_chk = 0, n_fail = 0;

  // bench model
  logic       m_en = 0, m_dma = 0, m_hold = 0;
  logic [1:0] m_trig = 0;
  logic [7:0] rxm[$], txm[$];

  always #4 clk = ~clk;

  fifo_ready_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fcr_we_i(fcr_we), .fcr_wdata_i(fcr_d),
    .thr_we_i(thr_we), .thr_wdata_i(thr_d),
    .rhr_re_i(rhr_re), .rhr_rdata_o(rhr_q),
    .rx_push_i(rx_push), .rx_data_i(rx_d),
    .tx_pop_i(tx_pop), .tx_data_o(tx_q), .tx_avail_o(tx_avail),
    .data_ready_o(dr), .rxrdy_no(rxrdy_n), .txrdy_no(txrdy_n)
  );

  function automatic int tlev(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic logic m1_act();
    return (rxm.size() >= tlev(m_trig)) || (m_hold && rxm.size() != 0);
  endfunction

  function automatic logic exp_rxrdy_n();
    if (m_en && m_dma) return !m1_act();
    return rxm.size() == 0;
  endfunction

  function automatic logic exp_txrdy_n();
    if (m_en && m_dma) return txm.size() == 16;
    return txm.size() != 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " rxrdy_no"}, rxrdy_n, exp_rxrdy_n());
    chk({tag, " txrdy_no"}, txrdy_n, exp_txrdy_n());
    chk({tag, " data_ready"}, dr, rxm.size() != 0);
    chk({tag, " tx_avail"}, tx_avail, txm.size() != 0);
    if (rxm.size() != 0) chk({tag, " rx head"}, rhr_q, rxm[0]);
    if (txm.size() != 0) chk({tag, " tx head"}, tx_q, txm[0]);
  endtask

  task automatic model_edge();
    logic fl_rx, fl_tx, hold_n;
    int cap, sz;
    hold_n = m1_act();
    fl_rx = fcr_we && (fcr_d[1] || fcr_d[0] != m_en);
    fl_tx = fcr_we && (fcr_d[2] || fcr_d[0] != m_en);
    cap = m_en ? 16 : 1;
    if (fl_rx) rxm.delete();
    else begin
      sz = rxm.size();
      if (rhr_re && sz > 0) void'(rxm.pop_front());
      if (rx_push && sz < cap) rxm.push_back(rx_d);
    end
    if (fl_tx) txm.delete();
    else begin
      sz = txm.size();
      if (tx_pop && sz > 0) void'(txm.pop_front());
      if (thr_we && sz < cap) txm.push_back(thr_d);
    end
    if (fcr_we) begin
      m_en = fcr_d[0]; m_dma = fcr_d[3]; m_trig = fcr_d[7:6];
    end
    m_hold = hold_n;
  endtask

  // called at negedge; drives one cycle, updates model, returns at next negedge
  task automatic step(input logic fw, input logic [7:0] fd, input logic tw, input logic [7:0] td,
                      input logic rr, input logic tp, input logic rp, input logic [7:0] rd);
    fcr_we = fw; fcr_d = fd; thr_we = tw; thr_d = td;
    rhr_re = rr; tx_pop = tp; rx_push = rp; rx_d = rd;
    @(posedge clk);
    #1;
    model_edge();
    fcr_we = 0; thr_we = 0; rhr_re = 0; tx_pop = 0; rx_push = 0;
    @(negedge clk);
  endtask

  task automatic wr_fcr(input logic [7:0] d); step(1, d, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr_tx(input logic [7:0] d);  step(0, 0, 1, d, 0, 0, 0, 0); endtask
  task automatic push_rx(input logic [7:0] d); step(0, 0, 0, 0, 0, 0, 1, d); endtask
  task automatic rd_rx();  step(0, 0, 0, 0, 1, 0, 0, 0); endtask
  task automatic pop_tx(); step(0, 0, 0, 0, 0, 1, 0, 0); endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rxrdy_no", rxrdy_n, 1);
    chk("R1 txrdy_no", txrdy_n, 0);
    chk("R1 data_ready", dr, 0);
    chk("R1 tx_avail", tx_avail, 0);

    // single-byte mode
    wr_tx(8'hA5);
    chk("R3 txrdy_no after write", txrdy_n, 1);
    wr_tx(8'h3C);
    chk("R2 tx second write ignored", tx_q, 8'hA5);
    pop_tx();
    chk("R3 txrdy_no after start", txrdy_n, 0);
    chk("R2 tx empty after start", tx_avail, 0);
    push_rx(8'h11);
    chk("R4 rxrdy_no after push", rxrdy_n, 0);
    chk("R9 data_ready", dr, 1);
    push_rx(8'h22);
    chk("R2 rx first byte kept", rhr_q, 8'h11);
    rd_rx();
    chk("R4 rxrdy_no after read", rxrdy_n, 1);
    chk("R4 data_ready after read", dr, 0);
    check_all("R2");

    // R12: style bits ignored with queueing off
    wr_fcr(8'hC8);
    push_rx(8'h33);
    chk("R12 rxrdy_no below threshold", rxrdy_n, 0);
    wr_tx(8'h44);
    chk("R12 txrdy_no one byte", txrdy_n, 1);
    rd_rx(); pop_tx();
    check_all("R12");

    // style 0
    wr_fcr(8'h01);
    for (int i = 0; i < 17; i++) begin
      push_rx(8'(i + 8'h40));
      if (i == 0) chk("R6 rxrdy_no one byte", rxrdy_n, 0);
    end
    check_all("R5");
    wr_tx(8'h01); wr_tx(8'h02);
    chk("R6 txrdy_no not empty", txrdy_n, 1);
    pop_tx();
    chk("R6 txrdy_no one left", txrdy_n, 1);
    pop_tx();
    chk("R6 txrdy_no empty", txrdy_n, 0);
    for (int i = 0; i < 16; i++) begin
      chk("R5 order", rhr_q, 8'(i + 8'h40));
      rd_rx();
    end
    chk("R5 extra push dropped", dr, 0);

    // style 1, threshold 4
    wr_fcr(8'h49);
    for (int i = 0; i < 3; i++) push_rx(8'(i));
    chk("R8 below threshold", rxrdy_n, 1);
    chk("R9 data_ready below threshold", dr, 1);
    push_rx(8'h03);
    chk("R8 at threshold", rxrdy_n, 0);
    rd_rx(); rd_rx(); rd_rx();
    chk("R8 held until empty", rxrdy_n, 0);
    rd_rx();
    chk("R8 released at empty", rxrdy_n, 1);
    for (int i = 0; i < 15; i++) wr_tx(8'(i));
    chk("R7 txrdy_no 15 bytes", txrdy_n, 0);
    wr_tx(8'hF0);
    chk("R7 txrdy_no full", txrdy_n, 1);
    wr_tx(8'hF1);
    pop_tx();
    chk("R7 txrdy_no after pop", txrdy_n, 0);
    check_all("R7");

    // flushes
    push_rx(8'h55); push_rx(8'h66);
    wr_fcr(8'h4B);
    chk("R10 rx flushed", dr, 0);
    chk("R10 tx untouched", tx_avail, 1);
    wr_fcr(8'h4D);
    chk("R10 tx flushed", tx_avail, 0);
    push_rx(8'h77);
    wr_fcr(8'h49);
    chk("R10 flush bit not stored", dr, 1);
    chk("R11 same enable keeps data", rhr_q, 8'h77);
    wr_fcr(8'h48);
    chk("R11 enable change flushes", dr, 0);
    check_all("R11");

    // seeded random traffic
    for (int n = 0; n < 4000; n++) begin
      logic fw;
      logic [7:0] fd;
      fw = ($urandom % 64) == 0;
      fd = 8'($urandom);
      if (($urandom % 4) != 0) fd[0] = m_en;
      step(fw, fd, ($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0,
           ($urandom % 3) == 0, ($urandom % 2) == 0, 8'($urandom));
      check_all("RND R8");
    end
    finish_run();
  end
endmodule